// File: doc/BRIEF.md
# PCI configuration address generator

This block converts one configuration-space request into the address, cycle-type flag and byte-aligned data that a bus engine needs to run a configuration cycle. A request names a bus number, a combined device/function byte, a register byte offset, an access size and, for writes, the data. Requests to bus 0 target devices on the local segment. They use a one-hot select line picked by the device number. Requests to any other bus are forwarded in the remote format. The access size is folded into a sparse-space address above a fixed configuration base.

The block holds one request at a time. While a cycle is pending, the bus engine sees a held address. When the engine reports completion, the block returns a single-cycle response. The response carries a status code and the read data aligned to the requested byte. If the device number or the access size cannot be served, the block answers at once and issues no bus cycle.

Top module: `pcfg_addr_gen`

## Requirements
- R1: A request to bus 0 sets `cyc_type` to 0. A request to any other bus sets `cyc_type` to 1.
- R2: For bus 0, configuration address bit (11 + device) is the only bit set in bits 31:11. The device is devfn[7:3]. The function, devfn[2:0], sits in bits 10:8. Offset bits 7:2 sit in bits 7:2, and bits 1:0 are 00.
- R3: On bus 0, a device number above MAX_DEV (default 12) gets a not-found response in the cycle after acceptance, and `cyc_valid` never rises for that request.
- R4: For any other bus, the configuration address holds zero in bits 31:24, the bus in 23:16, the devfn byte in 15:8 and offset bits 7:2 in 7:2, with bits 1:0 equal to 01.
- R5: `cyc_addr` equals CFG_BASE + configuration address × 32 + (size − 1) × 8. CFG_BASE defaults to 0x80_0000_0000.
- R6: Any size other than 1, 2 or 4 gets a not-found response and no bus cycle.
- R7: `cyc_wdata` is the write data shifted left by (offset mod 4) × 8 and truncated to 32 bits.
- R8: A successful read returns `cyc_rdata` shifted right by (offset mod 4) × 8, with zero fill. A successful write returns 0.
- R9: If `cyc_err` is set with `cyc_done`, the response has status 2 and data 0xFFFFFFFF. A not-found response (status 1) also carries 0xFFFFFFFF. Success is status 0.
- R10: `req_ready` drops in the cycle after acceptance and rises again only after the response. `rsp_valid` lasts exactly one cycle. `cyc_addr` holds steady while `cyc_valid` waits for `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| cyc_valid | output | 1 | Bus cycle requested |
| cyc_type | output | 1 | 0 = local cycle, 1 = forwarded cycle |
| cyc_write | output | 1 | Direction of the bus cycle |
| cyc_addr | output | 40 | Sparse-space cycle address |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_done | input | 1 | Bus engine finished the cycle |
| cyc_err | input | 1 | Bus engine saw a failure |
| cyc_rdata | input | 32 | Raw read data from the bus |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 bus error |
| rsp_rdata | output | 32 | Aligned read data |

## Verification
The assertions check the handshake on every cycle. They cover the response pulse width, ready being low while a cycle is pending, and the address holding during a wait. They also check that rejected requests never start a cycle, that a local select is one-hot, that the type flag follows the bus number, and that error responses carry all ones. Only the bench's sweeps can show the exact address packing for every device, function, offset and size. The same holds for the data shifts on each byte lane and the rule that a write returns zero data. The bench computes each of these arithmetically and compares it.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 32;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOTFOUND = 2'd1,
    ST_BUSERR   = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUSY = 2'd1,
    S_RESP = 2'd2
  } fsm_e;

  // (size - 1) * 8 for legal sizes; zero otherwise
  function automatic logic [4:0] size_term(input logic [2:0] sz);
    case (sz)
      3'd2:    size_term = 5'd8;
      3'd4:    size_term = 5'd24;
      default: size_term = 5'd0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    size_legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [DATA_W-1:0] lane_up(input logic [DATA_W-1:0] d,
                                                input logic [1:0] lane);
    lane_up = d << {lane, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] lane_down(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] lane);
    lane_down = d >> {lane, 3'b000};
  endfunction
endpackage

// File: rtl/pcfg_addr_decode.sv
module pcfg_addr_decode
  import pcfg_pkg::*;
#(
  parameter int MAX_DEV = 12,
  parameter int SPARSE_W = 40,
  parameter logic [SPARSE_W-1:0] CFG_BASE = 40'h80_0000_0000
) (
  input  logic [7:0]          bus,
  input  logic [7:0]          devfn,
  input  logic [7:0]          off,
  input  logic [2:0]          size,
  output logic                legal,
  output logic                fwd_type,
  output logic [CFG_W-1:0]    cfg_addr,
  output logic [SPARSE_W-1:0] sparse_addr
);
  localparam int SEL_N  = MAX_DEV + 1;
  localparam int SEL_LO = 11;

  logic [4:0]       dev;
  logic [2:0]       fn;
  logic [SEL_N-1:0] dev_sel;
  logic [CFG_W-1:0] local_addr, remote_addr;
  logic             dev_ok;

  assign dev = devfn[7:3];
  assign fn  = devfn[2:0];

  // one select line per addressable local device
  for (genvar g = 0; g < SEL_N; g++) begin : g_sel
    assign dev_sel[g] = (dev == 5'(g));
  end

  always_comb begin
    local_addr = '0;
    local_addr[SEL_LO +: SEL_N] = dev_sel;
    local_addr[10:8] = fn;
    local_addr[7:2]  = off[7:2];
  end

  assign remote_addr = {8'h00, bus, devfn, off[7:2], 2'b01};

  assign fwd_type = (bus != 8'h00);
  assign dev_ok   = fwd_type || (dev <= 5'(MAX_DEV));
  assign legal    = dev_ok && size_legal(size);
  assign cfg_addr = fwd_type ? remote_addr : local_addr;

  assign sparse_addr = (SPARSE_W'(cfg_addr) << 5) + SPARSE_W'(size_term(size)) + CFG_BASE;
endmodule

// File: rtl/pcfg_lane_align.sv
module pcfg_lane_align
  import pcfg_pkg::*;
(
  input  logic [DATA_W-1:0] wr_in,
  input  logic [1:0]        wr_lane,
  input  logic [DATA_W-1:0] rd_in,
  input  logic [1:0]        rd_lane,
  output logic [DATA_W-1:0] wr_out,
  output logic [DATA_W-1:0] rd_out
);
  assign wr_out = lane_up(wr_in, wr_lane);
  assign rd_out = lane_down(rd_in, rd_lane);
endmodule

// File: rtl/pcfg_addr_gen.sv
module pcfg_addr_gen
  import pcfg_pkg::*;
#(
  parameter int MAX_DEV = 12,
  parameter int SPARSE_W = 40,
  parameter logic [SPARSE_W-1:0] CFG_BASE = 40'h80_0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [7:0]          req_bus,
  input  logic [7:0]          req_devfn,
  input  logic [7:0]          req_off,
  input  logic [2:0]          req_size,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                cyc_valid,
  output logic                cyc_type,
  output logic                cyc_write,
  output logic [SPARSE_W-1:0] cyc_addr,
  output logic [DATA_W-1:0]   cyc_wdata,
  input  logic                cyc_done,
  input  logic                cyc_err,
  input  logic [DATA_W-1:0]   cyc_rdata,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [DATA_W-1:0]   rsp_rdata
);
  fsm_e                state_q;
  logic                dec_legal, dec_type;
  logic [CFG_W-1:0]    dec_cfg;
  logic [SPARSE_W-1:0] dec_sparse;
  logic [DATA_W-1:0]   wr_aligned, rd_aligned;
  logic [1:0]          lane_q;
  logic                type_q, write_q;
  logic [SPARSE_W-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  rsp_code_e           status_q;

  // named events
  logic accept_w, reject_w, launch_w, finish_w;

  pcfg_addr_decode #(.MAX_DEV(MAX_DEV), .SPARSE_W(SPARSE_W), .CFG_BASE(CFG_BASE)) u_dec (
    .bus(req_bus), .devfn(req_devfn), .off(req_off), .size(req_size),
    .legal(dec_legal), .fwd_type(dec_type), .cfg_addr(dec_cfg), .sparse_addr(dec_sparse)
  );

  pcfg_lane_align u_lane (
    .wr_in(req_wdata), .wr_lane(req_off[1:0]),
    .rd_in(cyc_rdata), .rd_lane(lane_q),
    .wr_out(wr_aligned), .rd_out(rd_aligned)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept_w  = req_valid && req_ready;
  assign launch_w  = accept_w && dec_legal;
  assign reject_w  = accept_w && !dec_legal;
  assign cyc_valid = (state_q == S_BUSY);
  assign finish_w  = cyc_valid && cyc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      lane_q   <= '0;
      type_q   <= 1'b0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      status_q <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (launch_w) begin
            state_q <= S_BUSY;
            lane_q  <= req_off[1:0];
            type_q  <= dec_type;
            write_q <= req_write;
            addr_q  <= dec_sparse;
            wdata_q <= req_write ? wr_aligned : '0;
          end else if (reject_w) begin
            state_q  <= S_RESP;
            status_q <= ST_NOTFOUND;
            rdata_q  <= '1;
          end
        end
        S_BUSY: begin
          if (finish_w) begin
            state_q <= S_RESP;
            if (cyc_err) begin
              status_q <= ST_BUSERR;
              rdata_q  <= '1;
            end else begin
              status_q <= ST_OK;
              rdata_q  <= write_q ? '0 : rd_aligned;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cyc_type   = type_q;
  assign cyc_write  = write_q;
  assign cyc_addr   = addr_q;
  assign cyc_wdata  = wdata_q;
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign rsp_rdata  = rdata_q;

  // ---------------- assertions ----------------
  p_type_follows_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |=> cyc_type == ($past(req_bus) != 8'h00));

  p_local_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_w && req_bus == 8'h00) |-> $countones(dec_cfg[CFG_W-1:11]) == 1);

  p_reject_no_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> (rsp_valid && !cyc_valid && rsp_status == ST_NOTFOUND));

  p_err_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_OK) |-> rsp_rdata == '1);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !req_ready);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_done) |=> (cyc_valid && $stable(cyc_addr)));
endmodule

// File: tb/pcfg_addr_gen_tb.sv
`timescale 1ns/1ps
module pcfg_addr_gen_tb_top;
  localparam longint BASE = 64'h80_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_off = '0;
  logic [2:0]  req_size = 3'd4;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        cyc_valid, cyc_type, cyc_write;
  logic [39:0] cyc_addr;
  logic [31:0] cyc_wdata;
  logic        cyc_done = 1'b0, cyc_err = 1'b0;
  logic [31:0] cyc_rdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcfg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .cyc_done(cyc_done), .cyc_err(cyc_err), .cyc_rdata(cyc_rdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one complete request with arithmetic expectations
  task automatic run_req(input int bus, input int devfn, input int off, input int size,
                         input bit wr, input longint wdata, input longint brdata, input bit berr);
    int dev = devfn / 8;
    int fn = devfn % 8;
    int lane = off % 4;
    bit size_ok = (size == 1) || (size == 2) || (size == 4);
    bit dev_ok = (bus != 0) || (dev <= 12);
    longint cfg, exp_addr, exp_wd, exp_rd;
    int exp_st;
    if (bus == 0) cfg = (longint'(1) << (11 + dev)) + fn * 256 + (off / 4) * 4;
    else          cfg = longint'(bus) * 65536 + devfn * 256 + (off / 4) * 4 + 1;
    exp_addr = BASE + cfg * 32 + (size - 1) * 8;
    exp_wd = (wdata * (longint'(1) << (8 * lane))) % (longint'(1) << 32);
    exp_rd = brdata / (longint'(1) << (8 * lane));

    @(negedge clk);
    req_valid = 1'b1; req_bus = 8'(bus); req_devfn = 8'(devfn); req_off = 8'(off);
    req_size = 3'(size); req_write = wr; req_wdata = 32'(wdata);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low after accept", longint'(req_ready), 0);
    if (!(size_ok && dev_ok)) begin
      chk(cyc_valid == 1'b0, size_ok ? "R3 no cycle" : "R6 no cycle", longint'(cyc_valid), 0);
      chk(rsp_valid && rsp_status == 2'd1,
          size_ok ? "R3 not-found status" : "R6 not-found status", longint'(rsp_status), 1);
      chk(rsp_rdata == 32'hFFFF_FFFF, "R9 not-found data", longint'(rsp_rdata), 64'hFFFF_FFFF);
    end else begin
      chk(cyc_valid == 1'b1, "R10 cycle raised", longint'(cyc_valid), 1);
      chk(cyc_type == (bus != 0), "R1 type flag", longint'(cyc_type), longint'(bus != 0));
      chk(longint'(cyc_addr) == exp_addr, bus == 0 ? "R2/R5 address" : "R4/R5 address",
          longint'(cyc_addr), exp_addr);
      if (wr) chk(longint'(cyc_wdata) == exp_wd, "R7 write data", longint'(cyc_wdata), exp_wd);
      @(negedge clk);
      chk(cyc_valid && longint'(cyc_addr) == exp_addr, "R10 address hold",
          longint'(cyc_addr), exp_addr);
      cyc_done = 1'b1; cyc_err = berr; cyc_rdata = 32'(brdata);
      @(negedge clk);
      cyc_done = 1'b0; cyc_err = 1'b0;
      exp_st = berr ? 2 : 0;
      if (berr) exp_rd = 64'hFFFF_FFFF;
      else if (wr) exp_rd = 0;
      chk(rsp_valid == 1'b1 && int'(rsp_status) == exp_st, "R9 status",
          longint'(rsp_status), longint'(exp_st));
      chk(longint'(rsp_rdata) == exp_rd, berr ? "R9 error data" : "R8 read data",
          longint'(rsp_rdata), exp_rd);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 one-cycle response",
        longint'(rsp_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cyc_valid && !rsp_valid, "R10 reset state", longint'(req_ready), 1);

    // R2/R3: every local device number, all functions, every lane, legal sizes
    for (int dev = 0; dev < 32; dev++)
      for (int fn = 0; fn < 8; fn++)
        for (int lane = 0; lane < 4; lane++)
          for (int s = 0; s < 3; s++)
            run_req(0, dev * 8 + fn, 4 * ((dev + fn) % 64) + lane, (s == 2) ? 4 : s + 1,
                    bit'((fn + lane) % 2), 64'hA1B2_C3D4 + dev, 64'h1234_5678 + fn * 16, 1'b0);

    // R4/R1: forwarded buses with varied devfn and offsets
    for (int bus = 1; bus < 256; bus++)
      run_req(bus, (bus * 37) % 256, (bus * 13) % 256, 4, bit'(bus % 2),
              64'hDEAD_BEEF, 64'hCAFE_F00D, 1'b0);

    // R6: every illegal size on both cycle types
    for (int sz = 0; sz < 8; sz++) begin
      run_req(0, 8, 4, sz, 1'b0, 0, 64'h5555_AAAA, 1'b0);
      run_req(3, 8, 5, sz, 1'b1, 64'h77, 0, 1'b0);
    end

    // R9: bus error on reads and writes, every lane
    for (int lane = 0; lane < 4; lane++) begin
      run_req(0, 12 * 8, 8 + lane, 1, 1'b0, 0, 64'h0BAD_F00D, 1'b1);
      run_req(9, 3, 16 + lane, 2, 1'b1, 64'h1, 0, 1'b1);
    end

    // R8: read lanes with distinctive bytes
    for (int lane = 0; lane < 4; lane++)
      run_req(0, 0, lane, 1, 1'b0, 0, 64'h8877_6655, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule